// File: doc/BRIEF.md
# Stateless Corrective Input Selector

This block is a purely combinational selector. It sits between an external command source and the input channel of a controlled asynchronous sequential machine. It sees three things: the external command, the machine's current settled state, and a fault code from a separate diagnoser. When the fault code is zero, it hands the external command straight to the machine. When the fault code names a fault origin, it steers the machine back along a recovery path. The steering command comes from a table. That table is keyed by the pair (fault code, settled state) and is fixed when the block is built.

The block holds no storage. Progress along a recovery path is carried only by the settled state that is fed back. A given external command and state can therefore mean "relay" while no fault is flagged and "steer back" while one is, with no conflict. Only settled states are ever presented to the block, never the transient states inside a transition. The external command is assumed to hold still while a recovery is in progress.

The table parameter packs `NREC` rows of `IDX_W+ST_W+IN_W` bits. Row k sits at bits `[k*ENTRY_W +: ENTRY_W]`. Inside a row, the command occupies the low `IN_W` bits, the state the next `ST_W` bits, and the fault code the top `IDX_W` bits, where `IDX_W = clog2(NFAULT+1)`. Fault code 0 means "no fault".

Top module: `corrective_selector`

## Requirements
- R1: With fault code 0, `ctrl_cmd` equals `ext_cmd` for every settled state, including states that appear in the table.
- R2: With a nonzero fault code i and a settled state equal to the faulty state of a table row for i, `ctrl_cmd` is that row's command, which is the first symbol of the recovery string.
- R3: As the settled state walks through the intermediate states of a recovery path for fault i, `ctrl_cmd` follows the listed command of each state in turn. Once the fault code returns to 0 at the origin state, `ctrl_cmd` is again `ext_cmd`.
- R4: The output is a single-valued function of (`ext_cmd`, `stable_state`, `fault_idx`). No (fault, state) key in the table may carry two different commands, and every row's fault code must lie in 1..NFAULT. Applying the same triple again always yields the same output.
- R5: For a nonzero fault code whose (fault, state) key is not in the table, `ctrl_cmd` follows the miss policy. `MISS_RELAY` gives `ext_cmd`; `MISS_FIXED` gives the constant `MISS_CMD`.
- R6: The fault code selects the table. The same settled state under two different nonzero fault codes yields each code's own command.
- R7: While a listed (fault, state) key is presented, changing `ext_cmd` has no effect on `ctrl_cmd`.
- R8: `ctrl_cmd` differs from `ext_cmd` only while the fault code is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_cmd | input | IN_W | External command symbol |
| stable_state | input | ST_W | Current settled state of the controlled machine |
| fault_idx | input | IDX_W | Fault code from the diagnoser; 0 means no fault |
| ctrl_cmd | output | IN_W | Command applied to the controlled machine |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero register stages from any input to `ctrl_cmd`. The bench therefore changes inputs on the falling clock edge and samples the output 1 ns later, well inside the same half period. No check waits on a clock edge. The exhaustive pass over all triples is repeated in reverse order, which shows that the output depends only on the triple presented and not on what came before.

// File: rtl/csel_pkg.sv
package csel_pkg;

   typedef enum logic {
      MISS_RELAY = 1'b0,
      MISS_FIXED = 1'b1
   } miss_policy_e;

   function automatic int unsigned idx_width(input int unsigned nfault);
      int unsigned w;
      w = 1;
      while ((1 << w) < (nfault + 1)) w++;
      return w;
   endfunction

endpackage

// File: rtl/csel_row_match.sv
module csel_row_match #(
   parameter int unsigned IN_W = 2,
   parameter int unsigned ST_W = 3,
   parameter int unsigned IDX_W = 1,
   parameter logic [IDX_W-1:0] ROW_FAULT = '0,
   parameter logic [ST_W-1:0] ROW_STATE = '0,
   parameter logic [IN_W-1:0] ROW_CMD = '0
) (
   input  logic [IDX_W-1:0] fault_idx,
   input  logic [ST_W-1:0]  stable_state,
   output logic             hit,
   output logic [IN_W-1:0]  cmd
);

   always_comb begin
      hit = (fault_idx == ROW_FAULT) && (stable_state == ROW_STATE);
      cmd = ROW_CMD;
   end

   // R2: a table row may only answer while a fault is flagged
   always_comb begin
      if (hit) a_r2_hit_needs_fault: assert (fault_idx != '0)
         else $error("row hit with zero fault code");
   end

endmodule

// File: rtl/csel_first_hit.sv
module csel_first_hit #(
   parameter int unsigned IN_W = 2,
   parameter int unsigned NREC = 1
) (
   input  logic [NREC-1:0]      hits,
   input  logic [NREC*IN_W-1:0] cmds,
   output logic                 any_hit,
   output logic [IN_W-1:0]      cmd
);

   always_comb begin
      any_hit = 1'b0;
      cmd     = '0;
      for (int k = NREC - 1; k >= 0; k--) begin
         if (hits[k]) begin
            any_hit = 1'b1;
            cmd     = cmds[k*IN_W +: IN_W];
         end
      end
   end

   // R4: every row that answers at once must agree with the chosen command
   always_comb begin
      for (int k = 0; k < NREC; k++) begin
         if (hits[k]) a_r4_hits_agree: assert (cmds[k*IN_W +: IN_W] == cmd)
            else $error("two table rows give different commands");
      end
   end

endmodule

// File: rtl/csel_miss_path.sv
module csel_miss_path
   import csel_pkg::*;
#(
   parameter int unsigned IN_W = 2,
   parameter miss_policy_e MISS_POLICY = MISS_RELAY,
   parameter logic [IN_W-1:0] MISS_CMD = '0
) (
   input  logic [IN_W-1:0] ext_cmd,
   output logic [IN_W-1:0] miss_cmd
);

   generate
      if (MISS_POLICY == MISS_RELAY) begin : g_relay
         always_comb miss_cmd = ext_cmd;
      end else begin : g_fixed
         always_comb miss_cmd = MISS_CMD;
         // the fixed command must not depend on ext_cmd (mode is chosen at elaboration)
         logic unused_ext;
         always_comb unused_ext = ^ext_cmd;
      end
   endgenerate

endmodule

// File: rtl/corrective_selector.sv
module corrective_selector
   import csel_pkg::*;
#(
   parameter int unsigned IN_W = 2,
   parameter int unsigned ST_W = 3,
   parameter int unsigned NFAULT = 1,
   parameter int unsigned NREC = 1,
   parameter logic [NREC*(csel_pkg::idx_width(NFAULT)+ST_W+IN_W)-1:0] RECOVERY_TABLE = 6'b100000,
   parameter miss_policy_e MISS_POLICY = MISS_RELAY,
   parameter logic [IN_W-1:0] MISS_CMD = '0
) (
   input  logic [IN_W-1:0]                       ext_cmd,
   input  logic [ST_W-1:0]                       stable_state,
   input  logic [csel_pkg::idx_width(NFAULT)-1:0] fault_idx,
   output logic [IN_W-1:0]                       ctrl_cmd
);

   localparam int unsigned IDX_W   = csel_pkg::idx_width(NFAULT);
   localparam int unsigned ENTRY_W = IDX_W + ST_W + IN_W;

   function automatic bit table_ok();
      logic [ENTRY_W-1:0] ra, rb;
      bit ok;
      ok = 1'b1;
      for (int a = 0; a < NREC; a++) begin
         ra = RECOVERY_TABLE[a*ENTRY_W +: ENTRY_W];
         if (ra[IN_W+ST_W +: IDX_W] == '0) ok = 1'b0;
         if (int'(ra[IN_W+ST_W +: IDX_W]) > NFAULT) ok = 1'b0;
         for (int b = a + 1; b < NREC; b++) begin
            rb = RECOVERY_TABLE[b*ENTRY_W +: ENTRY_W];
            if (ra[IN_W +: ST_W+IDX_W] == rb[IN_W +: ST_W+IDX_W] &&
                ra[IN_W-1:0] != rb[IN_W-1:0]) ok = 1'b0;
         end
      end
      return ok;
   endfunction

   initial begin
      a_cfg_widths: assert (IN_W >= 1 && ST_W >= 1 && NFAULT >= 1 && NREC >= 1)
         else $error("selector widths and counts must be at least one");
      a_r4_table_consistent: assert (table_ok())
         else $error("recovery table has a conflicting key or a bad fault code");
   end

   logic [NREC-1:0]      row_hit;
   logic [NREC*IN_W-1:0] row_cmd;
   logic                 any_hit;
   logic [IN_W-1:0]      hit_cmd;
   logic [IN_W-1:0]      miss_cmd;

   generate
      for (genvar k = 0; k < NREC; k++) begin : g_row
         localparam logic [ENTRY_W-1:0] ROW = RECOVERY_TABLE[k*ENTRY_W +: ENTRY_W];
         csel_row_match #(
            .IN_W      (IN_W),
            .ST_W      (ST_W),
            .IDX_W     (IDX_W),
            .ROW_FAULT (ROW[IN_W+ST_W +: IDX_W]),
            .ROW_STATE (ROW[IN_W +: ST_W]),
            .ROW_CMD   (ROW[IN_W-1:0])
         ) u_row (
            .fault_idx    (fault_idx),
            .stable_state (stable_state),
            .hit          (row_hit[k]),
            .cmd          (row_cmd[k*IN_W +: IN_W])
         );
      end
   endgenerate

   csel_first_hit #(.IN_W(IN_W), .NREC(NREC)) u_pick (
      .hits    (row_hit),
      .cmds    (row_cmd),
      .any_hit (any_hit),
      .cmd     (hit_cmd)
   );

   csel_miss_path #(.IN_W(IN_W), .MISS_POLICY(MISS_POLICY), .MISS_CMD(MISS_CMD)) u_miss (
      .ext_cmd  (ext_cmd),
      .miss_cmd (miss_cmd)
   );

   always_comb begin
      if (fault_idx == '0)  ctrl_cmd = ext_cmd;
      else if (any_hit)     ctrl_cmd = hit_cmd;
      else                  ctrl_cmd = miss_cmd;
   end

   // R8: a departure from the external command needs a flagged fault
   always_comb begin
      if (ctrl_cmd != ext_cmd) a_r8_change_needs_fault: assert (fault_idx != '0)
         else $error("command altered with no fault flagged");
   end

   // R1: no table row may answer while no fault is flagged
   always_comb begin
      if (fault_idx == '0) a_r1_idle_no_hit: assert (!any_hit)
         else $error("table answered with zero fault code");
   end

   generate
      if (MISS_POLICY == MISS_RELAY) begin : g_chk_relay
         // R5: an unlisted key under relay policy passes the external command
         always_comb begin
            if (fault_idx != '0 && !any_hit) a_r5_miss_relays: assert (ctrl_cmd == ext_cmd)
               else $error("miss did not relay the external command");
         end
      end else begin : g_chk_fixed
         // R5: an unlisted key under fixed policy gives the fixed command
         always_comb begin
            if (fault_idx != '0 && !any_hit) a_r5_miss_fixed: assert (ctrl_cmd == MISS_CMD)
               else $error("miss did not give the fixed command");
         end
      end
   endgenerate

endmodule

// File: tb/corrective_selector_test.sv
module corrective_selector_test;
   import csel_pkg::*;

   // rows {fault[1:0], state[2:0], cmd[1:0]}
   localparam logic [6:0] E0 = {2'd1, 3'd5, 2'd2};
   localparam logic [6:0] E1 = {2'd1, 3'd6, 2'd1};
   localparam logic [6:0] E2 = {2'd1, 3'd7, 2'd2};
   localparam logic [6:0] E3 = {2'd2, 3'd5, 2'd3};
   localparam logic [6:0] E4 = {2'd2, 3'd0, 2'd1};
   localparam logic [6:0] E5 = {2'd3, 3'd2, 2'd0};
   localparam logic [41:0] TBL = {E5, E4, E3, E2, E1, E0};
   localparam logic [1:0] FIX = 2'd3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0] ext_cmd, fault_idx, out_relay, out_fixed;
   logic [2:0] stable_state;
   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;

   corrective_selector #(.IN_W(2), .ST_W(3), .NFAULT(3), .NREC(6), .RECOVERY_TABLE(TBL),
      .MISS_POLICY(MISS_RELAY), .MISS_CMD(2'd0)) uut (
      .ext_cmd(ext_cmd), .stable_state(stable_state), .fault_idx(fault_idx), .ctrl_cmd(out_relay));

   corrective_selector #(.IN_W(2), .ST_W(3), .NFAULT(3), .NREC(6), .RECOVERY_TABLE(TBL),
      .MISS_POLICY(MISS_FIXED), .MISS_CMD(FIX)) uut_fixed (
      .ext_cmd(ext_cmd), .stable_state(stable_state), .fault_idx(fault_idx), .ctrl_cmd(out_fixed));

   function automatic logic [1:0] model(input logic [1:0] e, input logic [2:0] s,
                                        input logic [1:0] f, input bit fixed);
      if (f == 2'd0) return e;
      for (int k = 0; k < 6; k++)
         if (TBL[k*7+5 +: 2] == f && TBL[k*7+2 +: 3] == s) return TBL[k*7 +: 2];
      return fixed ? FIX : e;
   endfunction

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: ext=%0d st=%0d fault=%0d got %0d expected %0d",
                  req, ext_cmd, stable_state, fault_idx, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] e, input logic [2:0] s, input logic [1:0] f);
      @(negedge clk);
      ext_cmd = e; stable_state = s; fault_idx = f;
      #1;
   endtask

   // {ext, state, fault, exp_relay, exp_fixed, req}
   localparam int NV = 12;
   localparam logic [14:0] VEC [NV] = '{
      {2'd1, 3'd5, 2'd0, 2'd1, 2'd1, 4'd1},  // R1 listed state, idle
      {2'd3, 3'd7, 2'd0, 2'd3, 2'd3, 4'd1},  // R1
      {2'd0, 3'd5, 2'd1, 2'd2, 2'd2, 4'd2},  // R2 faulty state
      {2'd0, 3'd2, 2'd3, 2'd0, 2'd0, 4'd2},  // R2
      {2'd3, 3'd7, 2'd1, 2'd2, 2'd2, 4'd3},  // R3 path start
      {2'd3, 3'd6, 2'd1, 2'd1, 2'd1, 4'd3},  // R3 intermediate
      {2'd3, 3'd5, 2'd2, 2'd3, 2'd3, 4'd6},  // R6 same state other fault
      {2'd3, 3'd5, 2'd1, 2'd2, 2'd2, 4'd6},  // R6
      {2'd1, 3'd5, 2'd1, 2'd2, 2'd2, 4'd7},  // R7 ext changed, same key
      {2'd2, 3'd0, 2'd2, 2'd1, 2'd1, 4'd7},  // R7
      {2'd1, 3'd4, 2'd1, 2'd1, 2'd3, 4'd5},  // R5 unlisted key
      {2'd2, 3'd3, 2'd3, 2'd2, 2'd3, 4'd5}   // R5
   };

   logic [1:0] seen_r [128];
   logic [1:0] seen_f [128];

   initial begin
      ext_cmd = 2'd2; stable_state = 3'd5; fault_idx = 2'd0;
      #1;
      check("R1 start", out_relay, 2'd2);
      check("R8 start", out_fixed, 2'd2);

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][14:13], VEC[v][12:10], VEC[v][9:8]);
         check($sformatf("R%0d vec%0d relay", VEC[v][3:0], v), out_relay, VEC[v][7:6]);
         check($sformatf("R%0d vec%0d fixed", VEC[v][3:0], v), out_fixed, VEC[v][5:4]);
      end

      // R3 walk: origin state 4, fault lands at 7, steer 7->6->5->4
      apply(2'd0, 3'd7, 2'd1); check("R3 walk s7", out_relay, 2'd2);
      apply(2'd0, 3'd6, 2'd1); check("R3 walk s6", out_relay, 2'd1);
      apply(2'd0, 3'd5, 2'd1); check("R3 walk s5", out_relay, 2'd2);
      apply(2'd0, 3'd4, 2'd0); check("R3 walk origin", out_relay, 2'd0);

      // R7: ext sweep while a listed key holds
      for (int e = 0; e < 4; e++) begin
         apply(2'(e), 3'd6, 2'd1);
         check("R7 ext sweep", out_relay, 2'd1);
      end

      // R4 exhaustive forward pass against the model
      for (int n = 0; n < 128; n++) begin
         apply(2'(n >> 5), 3'(n >> 2), 2'(n));
         check("R4 forward relay", out_relay, model(2'(n >> 5), 3'(n >> 2), 2'(n), 1'b0));
         check("R4 forward fixed", out_fixed, model(2'(n >> 5), 3'(n >> 2), 2'(n), 1'b1));
         check("R8 forward", (out_relay != ext_cmd && fault_idx == 2'd0) ? 2'd1 : 2'd0, 2'd0);
         seen_r[n] = out_relay;
         seen_f[n] = out_fixed;
      end
      // R4 reverse pass: same triple must give the same output
      for (int n = 127; n >= 0; n--) begin
         apply(2'(n >> 5), 3'(n >> 2), 2'(n));
         check("R4 reverse relay", out_relay, seen_r[n]);
         check("R4 reverse fixed", out_fixed, seen_f[n]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, got %0d cycles expected under 20000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule